// File: doc/BRIEF.md
# Vertical Line-Averaging Decimator for Inset Video

This block sits between the sampling front end of an inset (picture-in-picture) video path and the field store. It takes a raster of 6-bit luma and two 6-bit colour-difference samples, one pixel per valid cycle. Two strobes mark the first pixel of a field and the first pixel of a line. The block shrinks the picture vertically by keeping one line out of every three or every four. When smoothing is on, it first blends each kept line with the two lines above it, using weights of one quarter, one half and one quarter. Each kept pixel comes out as a one-cycle write strobe, together with the output line number and the column number. These are used to address the field store directly.

The kept-line ratio follows the inset size. The larger inset keeps every third line, up to 71 stored lines. The smaller inset keeps every fourth line, up to 53 stored lines. A freeze input stops all writes. It is sampled only at field boundaries, so the stored image is always a complete field. A pending flag shows that a field is being written and drops when the last pixel of the last stored line has been written.

Top module: `vdecim_filter`

## Requirements
- R1: While reset is asserted and after its release, `wr_valid` and `wr_pending` are 0 until a field is written.
- R2: With `filt_en` = 0, each written Y, U and V sample equals the input sample of the kept line. The write appears on the cycle after the input pixel is accepted.
- R3: With `filt_en` = 1, each written component equals min(63, (a + 2b + c + 2) >> 2). Here c is the current line's sample at that column, b is the previous line's and a is the one from two lines earlier. For lines 0 and 1 of a field, any line before line 0 is replaced by line 0.
- R4: The in-field input line index k counts from 0 at `pix_sof` and steps at each `pix_sol`. Line k is written only when k mod N = 0. N is 3 when `size_nine` = 1 and 4 when it is 0, and `size_nine` is sampled at `pix_sof`. The written `wr_line` is k / N and `wr_col` is the pixel position within the line, counting from 0.
- R5: At most 71 output lines (N = 3) or 53 output lines (N = 4) are written per field. Input lines beyond that produce no write.
- R6: `freeze` is sampled at `pix_sof`. A field that starts frozen produces no write at all, even if `freeze` is cleared during it. A field that starts unfrozen is written completely, even if `freeze` rises during it.
- R7: `wr_pending` becomes 1 after the `pix_sof` pixel of an unfrozen field. It returns to 0 on the same cycle as the write of the last column of the last output line. A frozen field leaves it unchanged.
- R8: Cycles with `pix_valid` = 0 produce no write, and so do pixels before the first `pix_sof` after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 = three-line blend, 0 = straight pass |
| size_nine | input | 1 | 1 = keep every 3rd line (71 max), 0 = every 4th (53 max) |
| freeze | input | 1 | Hold stored field (sampled at field start) |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_sof | input | 1 | First pixel of a field (implies first of a line) |
| pix_sol | input | 1 | First pixel of a line |
| pix_y | input | SW | Luma sample |
| pix_u | input | SW | First colour-difference sample |
| pix_v | input | SW | Second colour-difference sample |
| wr_valid | output | 1 | Write strobe to the field store |
| wr_line | output | OW | Output line index |
| wr_col | output | CW | Column index |
| wr_y | output | SW | Written luma |
| wr_u | output | SW | Written first colour-difference |
| wr_v | output | SW | Written second colour-difference |
| wr_pending | output | 1 | Field write in progress |

## Verification
The assertions assume that every line carries at most LINE_PIX pixels. They also assume that the strobes are only meaningful when `pix_valid` is high. The line-bound and pending-fall properties depend on this, because the column count saturates instead of wrapping. The stimulus always sends exactly LINE_PIX pixels per line. It raises `pix_sof` and `pix_sol` only together with a valid pixel. Idle cycles are placed between pixels at fixed intervals. The sweep covers both sizes, both filter settings, freeze changes during a field, fields longer and shorter than the output limit, and full-scale line patterns.

// File: rtl/vdecim_filter.sv
module vdecim_filter #(
  parameter int SW            = 6,
  parameter int LINE_PIX      = 128,
  parameter int LINES_NINE    = 71,
  parameter int LINES_SIXTEEN = 53
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                filt_en,
  input  logic                                size_nine,
  input  logic                                freeze,
  input  logic                                pix_valid,
  input  logic                                pix_sof,
  input  logic                                pix_sol,
  input  logic [SW-1:0]                       pix_y,
  input  logic [SW-1:0]                       pix_u,
  input  logic [SW-1:0]                       pix_v,
  output logic                                wr_valid,
  output logic [$clog2(LINES_NINE+1)-1:0]     wr_line,
  output logic [$clog2(LINE_PIX)-1:0]         wr_col,
  output logic [SW-1:0]                       wr_y,
  output logic [SW-1:0]                       wr_u,
  output logic [SW-1:0]                       wr_v,
  output logic                                wr_pending
);
  localparam int CW = $clog2(LINE_PIX);
  localparam int OW = $clog2(LINES_NINE+1);
  localparam int PW = 3*SW;
  localparam logic [CW-1:0]   COL_LAST = CW'(LINE_PIX-1);
  localparam logic [OW-1:0]   LIM9     = OW'(LINES_NINE);
  localparam logic [OW-1:0]   LIM16    = OW'(LINES_SIXTEEN);
  localparam logic [SW+2:0]   TOPV     = (SW+3)'((1 << SW) - 1);

  function automatic logic [SW-1:0] blend(input logic [SW-1:0] a, b, c);
    logic [SW+2:0] s;
    s = {3'b000, a} + {2'b00, b, 1'b0} + {3'b000, c} + (SW+3)'(2);
    s = s >> 2;
    return (s > TOPV) ? TOPV[SW-1:0] : s[SW-1:0];
  endfunction

  logic          act_q, frz_q, sz_q;
  logic [CW-1:0] col_q;
  logic [1:0]    ph_q, seen_q;
  logic [OW-1:0] oi_q;
  logic [PW-1:0] lb1 [LINE_PIX];
  logic [PW-1:0] lb2 [LINE_PIX];

  wire sof = pix_valid & pix_sof;
  wire sol = pix_valid & (pix_sof | pix_sol);
  wire act_n = act_q | sof;
  wire frz_n = sof ? freeze : frz_q;
  wire sz_n  = sof ? size_nine : sz_q;
  wire [1:0]    ph_last = sz_n ? 2'd2 : 2'd3;
  wire [OW-1:0] lim_n   = sz_n ? LIM9 : LIM16;

  logic [CW-1:0] col_n;
  logic [1:0]    ph_n, seen_n;
  logic [OW-1:0] oi_n;

  always_comb begin
    col_n  = col_q;
    ph_n   = ph_q;
    oi_n   = oi_q;
    seen_n = seen_q;
    if (sof) begin
      col_n = '0; ph_n = '0; oi_n = '0; seen_n = '0;
    end else if (sol) begin
      col_n  = '0;
      ph_n   = (ph_q == ph_last) ? 2'd0 : ph_q + 2'd1;
      if (ph_q == ph_last && oi_q != lim_n) oi_n = oi_q + OW'(1);
      if (seen_q != 2'd2) seen_n = seen_q + 2'd1;
    end else if (pix_valid && col_q != COL_LAST) begin
      col_n = col_q + CW'(1);
    end
  end

  wire keep = pix_valid & act_n & ~frz_n & (ph_n == 2'd0) & (oi_n < lim_n);

  wire [PW-1:0] cur = {pix_y, pix_u, pix_v};
  wire [PW-1:0] m1  = (seen_n == 2'd0) ? cur : lb1[col_n];
  wire [PW-1:0] m2  = (seen_n <= 2'd1) ? m1  : lb2[col_n];
  logic [PW-1:0] flt;

  for (genvar i = 0; i < 3; i++) begin : g_comp
    assign flt[i*SW +: SW] = blend(m2[i*SW +: SW], m1[i*SW +: SW], cur[i*SW +: SW]);
  end

  always_ff @(posedge clk) begin
    if (pix_valid) begin
      lb1[col_n] <= cur;
      lb2[col_n] <= lb1[col_n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; frz_q <= 1'b0; sz_q <= 1'b0;
      col_q <= '0; ph_q <= '0; oi_q <= '0; seen_q <= '0;
      wr_valid <= 1'b0; wr_line <= '0; wr_col <= '0;
      wr_y <= '0; wr_u <= '0; wr_v <= '0;
      wr_pending <= 1'b0;
    end else begin
      if (pix_valid) begin
        act_q <= act_n; frz_q <= frz_n; sz_q <= sz_n;
        col_q <= col_n; ph_q <= ph_n; oi_q <= oi_n; seen_q <= seen_n;
      end
      wr_valid <= keep;
      if (keep) begin
        wr_line <= oi_n;
        wr_col  <= col_n;
        {wr_y, wr_u, wr_v} <= filt_en ? flt : cur;
      end
      if (sof && !freeze)
        wr_pending <= 1'b1;
      else if (keep && oi_n == lim_n - OW'(1) && col_n == COL_LAST)
        wr_pending <= 1'b0;
    end
  end

  a_r8_write_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(pix_valid));
  a_r5_line_limit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_line < (sz_q ? LIM9 : LIM16));
  a_r6_frozen_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !frz_q && act_q);
  a_r7_pending_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_pending) |-> wr_valid && wr_col == COL_LAST
                          && wr_line == (sz_q ? LIM9 : LIM16) - OW'(1));
  a_r4_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) && wr_col != '0 |-> $stable(wr_line));
endmodule

// File: tb/vdecim_filter_tb.sv
module vdecim_filter_tb;
  localparam int SW = 6;
  localparam int LP = 4;
  localparam int OW = $clog2(71+1);
  localparam int CW = $clog2(LP);

  logic clk = 0, rst_n = 0;
  logic filt_en = 0, size_nine = 0, freeze = 0;
  logic pix_valid = 0, pix_sof = 0, pix_sol = 0;
  logic [SW-1:0] pix_y = 0, pix_u = 0, pix_v = 0;
  logic wr_valid, wr_pending;
  logic [OW-1:0] wr_line;
  logic [CW-1:0] wr_col;
  logic [SW-1:0] wr_y, wr_u, wr_v;

  int vecs = 0, errs = 0;
  bit done = 0;
  bit exp_frz = 0, exp_pend = 0;
  int pcount = 0;

  always #10 clk = ~clk;

  vdecim_filter #(.SW(SW), .LINE_PIX(LP)) u_dut (
    .clk, .rst_n, .filt_en, .size_nine, .freeze, .pix_valid, .pix_sof, .pix_sol,
    .pix_y, .pix_u, .pix_v, .wr_valid, .wr_line, .wr_col, .wr_y, .wr_u, .wr_v,
    .wr_pending);

  function automatic int pv(int fld, int pat, int ln, int col, int comp);
    if (pat == 1) return ((ln + comp) % 2 == 0) ? 63 : 0;
    return (fld*13 + ln*7 + col*29 + comp*17 + ((ln*ln) % 5)*9) % 64;
  endfunction

  function automatic int mix(int a, int b, int c);
    int s = (a + 2*b + c + 2) / 4;
    return (s > 63) ? 63 : s;
  endfunction

  task automatic chk(string tag, int act, int expv);
    vecs++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 0; pix_sof = 0; pix_sol = 0;
    @(posedge clk); #1;
    chk("R8 idle no write", wr_valid, 0);
    chk("R7 pending idle", wr_pending, exp_pend);
  endtask

  task automatic run_field(int fld, int pat, bit s9, bit fen, bit f0, int tgl, bit f1, int nl);
    int n = s9 ? 3 : 4;
    int lim = s9 ? 71 : 53;
    for (int k = 0; k < nl; k++) begin
      for (int c = 0; c < LP; c++) begin
        int ey, eu, ev;
        bit kp;
        string tg;
        if ((pcount++ % 7) == 6) idle();
        @(negedge clk);
        pix_valid = 1; pix_sof = (k == 0 && c == 0); pix_sol = (c == 0);
        size_nine = s9; filt_en = fen;
        freeze = (k >= tgl) ? f1 : f0;
        pix_y = SW'(pv(fld, pat, k, c, 0));
        pix_u = SW'(pv(fld, pat, k, c, 1));
        pix_v = SW'(pv(fld, pat, k, c, 2));
        if (k == 0 && c == 0) exp_frz = freeze;
        kp = !exp_frz && (k % n == 0) && (k / n < lim);
        if (fen) begin
          int k1 = (k >= 1) ? k-1 : 0;
          int k2 = (k >= 2) ? k-2 : 0;
          ey = mix(pv(fld,pat,k2,c,0), pv(fld,pat,k1,c,0), pv(fld,pat,k,c,0));
          eu = mix(pv(fld,pat,k2,c,1), pv(fld,pat,k1,c,1), pv(fld,pat,k,c,1));
          ev = mix(pv(fld,pat,k2,c,2), pv(fld,pat,k1,c,2), pv(fld,pat,k,c,2));
        end else begin
          ey = pv(fld,pat,k,c,0); eu = pv(fld,pat,k,c,1); ev = pv(fld,pat,k,c,2);
        end
        if (k == 0 && c == 0 && !freeze) exp_pend = 1;
        else if (kp && k/n == lim-1 && c == LP-1) exp_pend = 0;
        @(posedge clk); #1;
        if (exp_frz) tg = "R6 frozen field write";
        else if (k / n >= lim) tg = "R5 beyond line limit";
        else tg = "R4 kept-line strobe";
        chk(tg, wr_valid, kp);
        chk("R7 pending flag", wr_pending, exp_pend);
        if (kp && wr_valid) begin
          chk("R4 line index", wr_line, k / n);
          chk("R4 column index", wr_col, c);
          chk(fen ? "R3 blended Y" : "R2 pass Y", wr_y, ey);
          chk(fen ? "R3 blended U" : "R2 pass U", wr_u, eu);
          chk(fen ? "R3 blended V" : "R2 pass V", wr_v, ev);
        end
      end
    end
  endtask

  initial begin
    #(20*200000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset wr_valid", wr_valid, 0);
    chk("R1 reset wr_pending", wr_pending, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pix_valid = 1; pix_sof = 0; pix_sol = (i % LP == 0);
      pix_y = 6'd21; pix_u = 6'd5; pix_v = 6'd40;
      @(posedge clk); #1;
      chk("R8 no write before field", wr_valid, 0);
      chk("R1 pending after reset", wr_pending, 0);
    end
    run_field(1, 0, 1, 0, 0, 999, 0, 216);
    run_field(2, 0, 1, 1, 0, 999, 0, 216);
    run_field(3, 0, 0, 0, 0, 999, 0, 214);
    run_field(4, 0, 0, 1, 0, 999, 0, 214);
    run_field(5, 0, 1, 1, 0, 10, 1, 216);
    run_field(6, 0, 0, 1, 1, 20, 0, 214);
    run_field(7, 1, 0, 1, 0, 999, 0, 214);
    run_field(8, 1, 1, 0, 0, 999, 0, 30);
    run_field(9, 0, 1, 1, 0, 999, 0, 40);
    run_field(10, 0, 0, 1, 1, 999, 1, 12);
    idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule